// File: doc/BRIEF.md
# GPIO Pin Input and Interrupt Slice

This block is the logic for one general-purpose pin. It runs on a fast bus clock. A small bus port writes and reads a configuration word, and also reads and clears a status word. The pin input passes through two synchronizer stages in series. Each stage is set on its own to pass the signal straight through, to capture it on the falling clock edge, or to capture it on the rising clock edge.

The synchronized value feeds an interrupt detector. The detector supports rising, falling, any-edge, low-level and high-level triggers. Edge events are held in a sticky status flag until software clears it. Level triggers follow the synchronized input directly. The resulting interrupt source is routed to a maskable output, a non-maskable output, or both.

On the output side, the block drives the pad either push-pull or open drain. It also raises a wake request for a light-sleep controller when a level trigger matches.

Top module: `gpio_pin_unit`

## Requirements
- R1: After reset the configuration word reads 0, the status flag reads 0, and `irqOut`, `nmiOut` and `wakeReq` are 0. The output runs push-pull: `padOe` equals `outEn` and `padOut` equals `outData`.
- R2: Configuration bits and their fields:
  - A write with `busSel`=0 loads the configuration word.
  - Only these bits are kept: stage-1 select [1:0], stage-2 select [3:2], open-drain [4], trigger type [7:5], wake enable [10], interrupt enable [13], non-maskable enable [14].
  - All other bits read back as 0.
- R3: Each stage select code works as follows: 0 passes its input through without delay, 1 captures on the falling clock edge, and 2 or 3 capture on the rising clock edge. Stage 2 takes the output of stage 1.
- R4: Trigger types 1 (rising), 2 (falling) and 3 (any edge) compare the synchronized value with its value one rising edge earlier. Each matching transition sets status bit 0 once.
- R5: Writing status (`busSel`=1) with data bit 0 set clears the flag, and writing 0 leaves it unchanged. If an edge event and a clear arrive in the same cycle, the flag stays set.
- R6: Trigger type 4 makes the source equal to the inverted synchronized input, and type 5 makes it equal to the synchronized input. Neither is latched.
- R7: Trigger types 0, 6 and 7 never set the flag and never assert an interrupt.
- R8: `irqOut` is the interrupt source ANDed with config bit 13, and `nmiOut` is the source ANDed with bit 14. With an edge type the source is the status flag.
- R9: With the open-drain bit set, `padOut` is 0 and `padOe` equals `outEn` AND NOT `outData`.
- R10: `wakeReq` is 1 only when wake enable is set and trigger type 4 or 5 currently matches the synchronized input. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | 0 selects configuration, 1 selects status |
| busWrEn | input | 1 | Write strobe for the selected word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the selected word |
| padIn | input | 1 | Raw pad input |
| outData | input | 1 | Output data from the core |
| outEn | input | 1 | Output enable from the core |
| padOut | output | 1 | Value driven to the pad |
| padOe | output | 1 | Pad driver enable |
| irqOut | output | 1 | Maskable interrupt |
| nmiOut | output | 1 | Non-maskable interrupt |
| wakeReq | output | 1 | Light-sleep wake request |

## Verification
The bench runs through all sixteen pairs of stage codes, with latency checks where the captures on the two edges differ.

- A swapped falling/rising capture would show its level interrupt half a cycle late or early.
- Edge types are driven across repeated transitions. A detector that compared against the raw pad, or failed to register the old value, would raise the flag twice or miss it.
- Clearing in the same cycle as an edge checks that set wins; the wrong priority would lose an interrupt.
- Reserved trigger codes and the wake gating are exercised. A detector that treated code 6 or 7 as valid, or woke on edge types, would fail against the reference model.

// File: rtl/gpio_pin_pkg.sv
`timescale 1ns/1ps
package gpio_pin_pkg;
  localparam int BUS_W       = 32;
  localparam int SYNC_STAGES = 2;
  localparam int SEL_W       = 2;
  localparam int TRIG_W      = 3;
  localparam int OD_BIT      = 4;
  localparam int TRIG_LSB    = 5;
  localparam int WAKE_BIT    = 10;
  localparam int IRQ_BIT     = 13;
  localparam int NMI_BIT     = 14;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_ANY  = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5,
    TRIG_RSV6 = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_e;

  typedef struct packed {
    logic [SYNC_STAGES-1:0][SEL_W-1:0] stageSel;
    logic  openDrain;
    trig_e trig;
    logic  wakeEn;
    logic  irqEn;
    logic  nmiEn;
  } pin_cfg_t;

  typedef struct packed {
    logic clrFlag;
  } ctrl_strobe_t;

  function automatic logic [BUS_W-1:0] cfgPack(pin_cfg_t c);
    logic [BUS_W-1:0] v;
    v = '0;
    for (int k = 0; k < SYNC_STAGES; k++) v[SEL_W*k +: SEL_W] = c.stageSel[k];
    v[OD_BIT]              = c.openDrain;
    v[TRIG_LSB +: TRIG_W]  = c.trig;
    v[WAKE_BIT]            = c.wakeEn;
    v[IRQ_BIT]             = c.irqEn;
    v[NMI_BIT]             = c.nmiEn;
    return v;
  endfunction

  function automatic pin_cfg_t cfgUnpack(logic [BUS_W-1:0] v);
    pin_cfg_t c;
    for (int k = 0; k < SYNC_STAGES; k++) c.stageSel[k] = v[SEL_W*k +: SEL_W];
    c.openDrain = v[OD_BIT];
    c.trig      = trig_e'(v[TRIG_LSB +: TRIG_W]);
    c.wakeEn    = v[WAKE_BIT];
    c.irqEn     = v[IRQ_BIT];
    c.nmiEn     = v[NMI_BIT];
    return c;
  endfunction

  localparam logic [BUS_W-1:0] CFG_MASK = cfgPack(pin_cfg_t'('1));
endpackage

// File: rtl/gpio_sync_stage.sv
`timescale 1ns/1ps
module gpio_sync_stage
  import gpio_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic             dout
);
  logic posCap;
  logic negCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) posCap <= 1'b0;
    else       posCap <= din;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negCap <= 1'b0;
    else       negCap <= din;
  end

  always_comb begin
    if (sel == '0)      dout = din;
    else if (!sel[1])   dout = negCap;
    else                dout = posCap;
  end

  // R3: a rising-edge stage presents the input seen at the previous rising edge
  assert_rise_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    sel[1] |=> (!sel[1] || dout == $past(din)));
endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             flagIn,
  output pin_cfg_t         cfg,
  output ctrl_strobe_t     strobe,
  output logic [BUS_W-1:0] busRdData
);
  pin_cfg_t cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cfgReg <= pin_cfg_t'('0);
    else if (busWrEn && !busSel) cfgReg <= cfgUnpack(busWrData);
  end

  always_comb begin
    strobe         = '0;
    strobe.clrFlag = busWrEn && busSel && busWrData[0];
  end

  assign cfg       = cfgReg;
  assign busRdData = busSel ? {{(BUS_W-1){1'b0}}, flagIn} : cfgPack(cfgReg);

  // R2: a configuration write reads back as the written word with unused bits dropped
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busSel) |=> (cfgPack(cfgReg) == ($past(busWrData) & CFG_MASK)));
endmodule

// File: rtl/gpio_pin_dp.sv
`timescale 1ns/1ps
module gpio_pin_dp
  import gpio_pin_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  pin_cfg_t     cfg,
  input  ctrl_strobe_t strobe,
  input  logic         padIn,
  input  logic         outData,
  input  logic         outEn,
  output logic         padOut,
  output logic         padOe,
  output logic         flagOut,
  output logic         irqOut,
  output logic         nmiOut,
  output logic         wakeReq
);
  logic [SYNC_STAGES:0] chain;
  logic syncVal;
  logic prevVal;
  logic riseEv, fallEv, edgeHit, levelHit, edgeMode, srcHit;
  logic flagReg;

  assign chain[0] = padIn;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    gpio_sync_stage u_stage (
      .clk  (clk),
      .rstN (rstN),
      .sel  (cfg.stageSel[g]),
      .din  (chain[g]),
      .dout (chain[g+1])
    );
  end

  assign syncVal = chain[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= 1'b0;
    else       prevVal <= syncVal;
  end

  assign riseEv = syncVal && !prevVal;
  assign fallEv = !syncVal && prevVal;

  always_comb begin
    edgeHit  = 1'b0;
    levelHit = 1'b0;
    edgeMode = 1'b0;
    unique case (cfg.trig)
      TRIG_RISE: begin edgeMode = 1'b1; edgeHit = riseEv; end
      TRIG_FALL: begin edgeMode = 1'b1; edgeHit = fallEv; end
      TRIG_ANY:  begin edgeMode = 1'b1; edgeHit = riseEv || fallEv; end
      TRIG_LOW:  levelHit = !syncVal;
      TRIG_HIGH: levelHit = syncVal;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagReg <= 1'b0;
    else if (edgeHit)        flagReg <= 1'b1;
    else if (strobe.clrFlag) flagReg <= 1'b0;
  end

  assign srcHit  = edgeMode ? flagReg : levelHit;
  assign irqOut  = srcHit && cfg.irqEn;
  assign nmiOut  = srcHit && cfg.nmiEn;
  assign wakeReq = levelHit && cfg.wakeEn;
  assign flagOut = flagReg;

  always_comb begin
    if (cfg.openDrain) begin
      padOut = 1'b0;
      padOe  = outEn && !outData;
    end else begin
      padOut = outData;
      padOe  = outEn;
    end
  end

  // R4: an edge event always leaves the flag set
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> flagReg);
  // R4: the flag never rises without an edge event
  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!flagReg && !edgeHit) |=> !flagReg);
  // R5: a clear with no competing event empties the flag
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && strobe.clrFlag && !edgeHit) |=> !flagReg);
  // R10: a wake request agrees with the polarity of the chosen level trigger
  assert_wake_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ((cfg.trig == TRIG_HIGH) == syncVal));
endmodule

// File: rtl/gpio_pin_unit.sv
`timescale 1ns/1ps
module gpio_pin_unit
  import gpio_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  input  logic             padIn,
  input  logic             outData,
  input  logic             outEn,
  output logic             padOut,
  output logic             padOe,
  output logic             irqOut,
  output logic             nmiOut,
  output logic             wakeReq
);
  pin_cfg_t     cfg;
  ctrl_strobe_t strobe;
  logic         flag;

  gpio_pin_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .flagIn    (flag),
    .cfg       (cfg),
    .strobe    (strobe),
    .busRdData (busRdData)
  );

  gpio_pin_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .strobe  (strobe),
    .padIn   (padIn),
    .outData (outData),
    .outEn   (outEn),
    .padOut  (padOut),
    .padOe   (padOe),
    .flagOut (flag),
    .irqOut  (irqOut),
    .nmiOut  (nmiOut),
    .wakeReq (wakeReq)
  );
endmodule

// File: tb/gpio_pin_unit_test.sv
`timescale 1ns/1ps
module gpio_pin_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic padIn = 1'b0, outData = 1'b0, outEn = 1'b0;
  logic padOut, padOe, irqOut, nmiOut, wakeReq;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit finished = 0;

  localparam logic [31:0] KEEP = 32'h0000_64FF;

  always #2.5 clk = ~clk;

  gpio_pin_unit uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .outData(outData), .outEn(outEn), .padOut(padOut), .padOe(padOe),
    .irqOut(irqOut), .nmiOut(nmiOut), .wakeReq(wakeReq)
  );

  // reference model state
  logic [31:0] mCfg;
  logic mA1, mB1, mA2, mB2, mPrev, mFlag; // A = falling capture, B = rising capture

  function automatic logic pick(logic [1:0] code, logic raw, logic fallV, logic riseV);
    if (code == 2'd0) return raw;
    if (code == 2'd1) return fallV;
    return riseV;
  endfunction

  function automatic logic firstOut();
    return pick(mCfg[1:0], padIn, mA1, mB1);
  endfunction

  function automatic logic finalOut();
    return pick(mCfg[3:2], firstOut(), mA2, mB2);
  endfunction

  always @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      mA1 <= 1'b0; mA2 <= 1'b0;
    end else begin
      mA1 <= padIn;
      mA2 <= firstOut();
    end
  end

  always @(posedge clk or negedge rstN) begin
    logic s;
    logic hit;
    int t;
    if (!rstN) begin
      mCfg <= '0; mB1 <= 1'b0; mB2 <= 1'b0; mPrev <= 1'b0; mFlag <= 1'b0;
    end else begin
      s = finalOut();
      t = int'(mCfg[7:5]);
      hit = (t == 1 && s && !mPrev) || (t == 2 && !s && mPrev) || (t == 3 && s != mPrev);
      if (hit) mFlag <= 1'b1;
      else if (busWrEn && busSel && busWrData[0]) mFlag <= 1'b0;
      if (busWrEn && !busSel) mCfg <= busWrData & KEEP;
      mPrev <= s;
      mB1 <= padIn;
      mB2 <= firstOut();
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int t;
    logic s, lvl, src, od;
    t   = int'(mCfg[7:5]);
    s   = finalOut();
    lvl = (t == 4 && !s) || (t == 5 && s);
    src = (t >= 1 && t <= 3) ? mFlag : lvl;
    od  = mCfg[4];
    chk(phase, "irqOut",  {31'b0, irqOut},  {31'b0, src && mCfg[13]});
    chk(phase, "nmiOut",  {31'b0, nmiOut},  {31'b0, src && mCfg[14]});
    chk(phase, "wakeReq", {31'b0, wakeReq}, {31'b0, lvl && mCfg[10]});
    chk(phase, "padOut",  {31'b0, padOut},  {31'b0, od ? 1'b0 : outData});
    chk(phase, "padOe",   {31'b0, padOe},   {31'b0, od ? (outEn && !outData) : outEn});
    chk(phase, "busRdData", busRdData, busSel ? {31'b0, mFlag} : mCfg);
  endtask

  always begin
    @(posedge clk);
    #4;
    if (rstN && !finished) compareAll();
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wrCfg(logic [31:0] v);
    busSel = 1'b0; busWrEn = 1'b1; busWrData = v;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic wrStat(logic [31:0] v);
    busSel = 1'b1; busWrEn = 1'b1; busWrData = v;
    tick();
    busWrEn = 1'b0; busSel = 1'b0;
  endtask

  task automatic expRd(logic sel, logic [31:0] exp, string tag);
    busSel = sel;
    #3;
    chk(tag, sel ? "status" : "config", busRdData, exp);
  endtask

  function automatic logic [31:0] mk(int s1, int s2, bit od, int trig, bit wake, bit irq, bit nmi);
    return {17'b0, nmi, irq, 2'b0, wake, 2'b0, 3'(trig), od, 2'(s2), 2'(s1)};
  endfunction

  task automatic togglePad(int n);
    for (int i = 0; i < n; i++) begin
      padIn = ~padIn;
      tick(); tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    repeat (2) tick();
    #3;
    chk("R1", "config in reset", busRdData, 32'h0);
    chk("R1", "irq in reset", {31'b0, irqOut}, 32'h0);
    tick();
    rstN = 1'b1;
    tick();
    expRd(1'b0, 32'h0, "R1");
    tick();
    expRd(1'b1, 32'h0, "R1");
    chk("R1", "nmi after reset", {31'b0, nmiOut}, 32'h0);
    chk("R1", "wake after reset", {31'b0, wakeReq}, 32'h0);
    tick();
    outEn = 1'b1; outData = 1'b1; busSel = 1'b0;
    #3;
    chk("R1", "push-pull padOut", {31'b0, padOut}, 32'h1);
    chk("R1", "push-pull padOe", {31'b0, padOe}, 32'h1);

    // R2 configuration field mask
    phase = "R2";
    tick();
    wrCfg(32'hFFFF_FFFF);
    expRd(1'b0, KEEP, "R2");
    tick();
    wrCfg(32'hA5A5_1B3C);
    expRd(1'b0, 32'h0000_003C, "R2");
    tick();
    wrCfg(32'h0);

    // R9 output driver modes
    phase = "R9";
    for (int m = 0; m < 2; m++) begin
      wrCfg(mk(0, 0, m[0], 0, 0, 0, 0));
      for (int c = 0; c < 4; c++) begin
        outData = c[0]; outEn = c[1];
        #3;
        if (m == 1) chk("R9", "open-drain padOe", {31'b0, padOe}, {31'b0, c[1] && !c[0]});
        tick();
      end
    end
    wrCfg(32'h0);

    // R3 synchronizer codes, explicit latency
    phase = "R3";
    padIn = 1'b0;
    wrCfg(mk(0, 0, 0, 5, 0, 1, 0));
    padIn = 1'b1;
    #3; chk("R3", "bypass same cycle", {31'b0, irqOut}, 32'h1);
    tick(); padIn = 1'b0; tick();
    wrCfg(mk(2, 0, 0, 5, 0, 1, 0));
    tick();
    padIn = 1'b1;
    #3; chk("R3", "rise capture before edge", {31'b0, irqOut}, 32'h0);
    tick();
    #3; chk("R3", "rise capture after edge", {31'b0, irqOut}, 32'h1);
    tick(); padIn = 1'b0; tick(); tick();
    wrCfg(mk(1, 0, 0, 5, 0, 1, 0));
    tick();
    padIn = 1'b1;
    #3; chk("R3", "fall capture mid cycle", {31'b0, irqOut}, 32'h1);
    tick();
    wrCfg(mk(1, 1, 0, 5, 0, 1, 0));
    tick(); tick();
    padIn = 1'b0;
    #3; chk("R3", "two fall stages first cycle", {31'b0, irqOut}, 32'h1);
    tick();
    #3; chk("R3", "two fall stages second cycle", {31'b0, irqOut}, 32'h0);
    tick();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wrCfg(mk(a, b, 0, 5, 0, 1, 0));
        togglePad(3);
        padIn = 1'b1; tick(); padIn = 1'b0; tick(); tick(); tick();
      end
    end

    // R4 edge triggers, one event per transition
    phase = "R4";
    padIn = 1'b0;
    for (int t = 1; t <= 3; t++) begin
      wrCfg(mk(2, 2, 0, t, 0, 1, 1));
      tick(); tick(); tick();
      wrStat(32'h1);
      padIn = 1'b1; tick(); tick(); tick(); tick();
      expRd(1'b1, {31'b0, t != 2}, "R4");
      tick();
      wrStat(32'h1);
      padIn = 1'b0; tick(); tick(); tick(); tick();
      expRd(1'b1, {31'b0, t != 1}, "R4");
      tick();
      wrStat(32'h1);
      togglePad(4);
    end

    // R5 write-one-to-clear and priority
    phase = "R5";
    wrCfg(mk(0, 0, 0, 3, 0, 1, 0));
    padIn = ~padIn; tick();
    expRd(1'b1, 32'h1, "R5");
    tick();
    wrStat(32'h0);
    expRd(1'b1, 32'h1, "R5");
    tick();
    wrStat(32'h1);
    expRd(1'b1, 32'h0, "R5");
    tick();
    padIn = ~padIn;
    wrStat(32'h1);
    expRd(1'b1, 32'h1, "R5");
    tick();
    wrStat(32'h1);

    // R6 level triggers are transparent
    phase = "R6";
    for (int t = 4; t <= 5; t++) begin
      wrCfg(mk(0, 0, 0, t, 0, 1, 0));
      padIn = 1'b1;
      #3; chk("R6", "level high input", {31'b0, irqOut}, {31'b0, t == 5});
      tick(); padIn = 1'b0;
      #3; chk("R6", "level low input", {31'b0, irqOut}, {31'b0, t == 4});
      tick();
      togglePad(3);
    end

    // R7 disabled and reserved codes
    phase = "R7";
    for (int k = 0; k < 3; k++) begin
      int t;
      t = (k == 0) ? 0 : k + 5;
      wrCfg(mk(0, 0, 0, t, 1, 1, 1));
      togglePad(4);
      expRd(1'b1, 32'h0, "R7");
      chk("R7", "irq quiet", {31'b0, irqOut}, 32'h0);
      tick();
    end

    // R8 routing to maskable and non-maskable outputs
    phase = "R8";
    padIn = 1'b1;
    for (int e = 0; e < 4; e++) begin
      wrCfg(mk(0, 0, 0, 5, 0, e[0], e[1]));
      #3;
      chk("R8", "irq route", {31'b0, irqOut}, {31'b0, e[0]});
      chk("R8", "nmi route", {31'b0, nmiOut}, {31'b0, e[1]});
      tick();
    end

    // R10 wake request
    phase = "R10";
    for (int t = 1; t <= 5; t++) begin
      for (int w = 0; w < 2; w++) begin
        wrCfg(mk(0, 0, 0, t, w[0], 0, 0));
        padIn = 1'b1;
        #3; chk("R10", "wake high", {31'b0, wakeReq}, {31'b0, w[0] && t == 5});
        tick(); padIn = 1'b0;
        #3; chk("R10", "wake low", {31'b0, wakeReq}, {31'b0, w[0] && t == 4});
        tick();
      end
    end

    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule